// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs bus cycles for a 16-bit processor core that has a 20-bit address space and one shared set of sixteen address/data lines. A client inside the core raises a request that carries the address, the transfer direction, a memory-or-I/O space flag, a two-bit segment tag, a high-byte flag and the write data. The sequencer turns each request into a four-state cycle (T1, T2, T3, T4). In T1 it drives the address together with an address-latch strobe. In the later states it passes data. A slow target can stretch the cycle by holding the ready input low, which adds wait states (Tw) between T3 and T4.

Another bus master can ask for the bus with a hold request. The sequencer grants it only at a cycle boundary. It raises the acknowledge and takes away every output enable until the request is withdrawn. Floating the bus shows up as the enable outputs `adOe` and `busOe`. The pad ring turns these enables into tri-state buffers.

An active-high reset ends any cycle at once. The block stays inert for at least `RST_MIN` clocks counted from the first clock in which reset is high, even when the reset pulse is shorter than that.

Top module: `mux_bus_seq`

## Requirements
- R1: In T1, `ale` is high for exactly one clock, `adOe` is 1, `adOut` carries address bits 15:0, `addrStat` carries address bits 19:16, and `bheN` is 0 exactly when the high byte is requested.
- R2: From T2 through T4, `addrStat` carries the segment tag in bits 1:0 with bits 3:2 at zero. Between cycles `addrStat` is zero.
- R3: On a read, `rdN` is low in T2, T3 and every Tw and high in T4. `adOe` is 0 after T1. `denN` is low in T2, T3 and Tw. `dtR` is 0. `rdN` and `wrN` are never low together.
- R4: On a write, `wrN` is low in T2, T3 and every Tw and high in T4. `adOut` carries the write data with `adOe`=1 and `denN`=0 from T2 through T4. `dtR` is 1.
- R5: `ready` is sampled at the rising edge that ends T3 and at the edge that ends each Tw. While it is low, Tw states follow, with the strobes and data held.
- R6: Read data on `adIn` is captured at the edge that ends the last T3 or Tw. It appears on `rdData` while `reqDone` is high in T4. Values present on `adIn` in earlier states do not affect `rdData`.
- R7: `mIo` is 1 for memory and 0 for I/O, and it stays unchanged from T1 through T4.
- R8: `reqTaken` is high only when `reqValid` is high, the block is idle or in T4, `hold` is low and the block is out of reset. T1 follows in the next clock, so a request taken in T4 runs back to back.
- R9: With `hold` high while idle, `reqTaken` is 0. From the next clock `hlda`=1 with `busOe`=0, `adOe`=0 and `ale`=0. One clock after `hold` falls, `hlda`=0 and `busOe`=1, and a pending request starts in the clock after that.
- R10: A `hold` that rises during a cycle leaves `hlda` at 0 until T4 has completed. `hlda` rises in the clock that follows T4.
- R11: While `rst` is high, the outputs take their idle values in the same clock: `ale`=0, `rdN`=`wrN`=`denN`=1, `adOe`=0, `hlda`=0, `busOe`=1, `reqDone`=0. After reset, `addrStat`=0, `bheN`=1, `mIo`=1 and `dtR`=0.
- R12: A reset pulse shorter than `RST_MIN` (default 4) clocks still keeps `reqTaken` at 0 for `RST_MIN` clocks in total, counted from the first clock in which `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Client request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMem | input | 1 | 1 = memory space, 0 = I/O space |
| reqSeg | input | 2 | Segment tag shown as status |
| reqAddr | input | ADDR_W | Transfer address |
| reqHigh | input | 1 | High data byte involved |
| reqWdata | input | DATA_W | Write data |
| reqTaken | output | 1 | Request accepted at this edge |
| reqDone | output | 1 | High in T4 |
| rdData | output | DATA_W | Captured read data |
| adOut | output | DATA_W | Multiplexed address/data out |
| adOe | output | 1 | Enable for adOut |
| adIn | input | DATA_W | Multiplexed bus in |
| addrStat | output | ADDR_W-DATA_W | Upper address in T1, status after |
| ale | output | 1 | Address latch strobe |
| bheN | output | 1 | High-byte enable, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| denN | output | 1 | Transceiver enable, active low |
| dtR | output | 1 | 1 = transmit, 0 = receive |
| mIo | output | 1 | 1 = memory, 0 = I/O |
| ready | input | 1 | Target ready |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted |
| busOe | output | 1 | Enable for address/status/control outputs |

## Verification
The checker relies on a few properties of its inputs. `ready` and `hold` only change away from the rising edge. A rising `rst` immediately forces the idle strobes. Because of this, wait-state holding and segment status can be stated directly on the strobe pins, under a reset-disabled clock. The bench drives every input at the falling edge. It never lets `rst`, `hold` or `ready` glitch within a clock, and it raises reset only during or after a full cycle, so the properties see only legal input sequences.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4, ST_HOLD
  } busState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic clear;      // internal reset
    logic load;       // latch the request
    logic addrPhase;  // T1
    logic statPhase;  // T2..T4 incl. wait states
    logic drvData;    // write data on the bus
    logic capture;    // sample read data
  } dpCtl_t;
endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int RST_MIN = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   reqValid,
  input  logic   ready,
  input  logic   hold,
  input  logic   isWrite,
  output dpCtl_t ctl,
  output logic   ale,
  output logic   rdN,
  output logic   wrN,
  output logic   denN,
  output logic   hlda,
  output logic   busOe,
  output logic   reqTaken,
  output logic   reqDone
);
  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(RST_MIN);

  logic [CW-1:0] rstCnt;
  logic          inReset;
  busState_t     state, nextState, cur;
  logic          strobeOn, dataOn, canStart;

  // reset stretch: counts from first high clock up to RST_MIN
  always_ff @(posedge clk) begin
    if (rst) begin
      if (rstCnt < CNT_TOP) rstCnt <= rstCnt + 1'b1;
    end else if (rstCnt != '0 && rstCnt < CNT_TOP) begin
      rstCnt <= rstCnt + 1'b1;
    end else begin
      rstCnt <= '0;
    end
  end

  assign inReset = rst || (rstCnt != '0 && rstCnt < CNT_TOP);
  assign cur     = inReset ? ST_IDLE : state;
  assign canStart = (cur == ST_IDLE || cur == ST_T4) && !hold && !inReset;

  always_comb begin
    nextState = cur;
    unique case (cur)
      ST_IDLE: if (hold) nextState = ST_HOLD;
               else if (reqValid) nextState = ST_T1;
      ST_T1:   nextState = ST_T2;
      ST_T2:   nextState = ST_T3;
      ST_T3,
      ST_TW:   nextState = ready ? ST_T4 : ST_TW;
      ST_T4:   if (hold) nextState = ST_HOLD;
               else if (reqValid) nextState = ST_T1;
               else nextState = ST_IDLE;
      ST_HOLD: nextState = hold ? ST_HOLD : ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    state <= inReset ? ST_IDLE : nextState;
  end

  assign strobeOn = (cur == ST_T2) || (cur == ST_T3) || (cur == ST_TW);
  assign dataOn   = strobeOn || (cur == ST_T4);

  assign ale      = (cur == ST_T1);
  assign rdN      = !(strobeOn && !isWrite);
  assign wrN      = !(strobeOn && isWrite);
  assign denN     = !(isWrite ? dataOn : strobeOn);
  assign hlda     = (cur == ST_HOLD);
  assign busOe    = (cur != ST_HOLD);
  assign reqTaken = canStart && reqValid;
  assign reqDone  = (cur == ST_T4);

  always_comb begin
    ctl.clear     = inReset;
    ctl.load      = reqTaken;
    ctl.addrPhase = (cur == ST_T1);
    ctl.statPhase = dataOn;
    ctl.drvData   = isWrite && dataOn;
    ctl.capture   = !isWrite && ready && ((cur == ST_T3) || (cur == ST_TW));
  end
endmodule

// File: rtl/mbus_dp.sv
module mbus_dp
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  dpCtl_t            ctl,
  input  logic              reqWrite,
  input  logic              reqMem,
  input  logic [1:0]        reqSeg,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqHigh,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output logic              isWrite,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W-DATA_W-1:0] addrStat,
  output logic              mIo,
  output logic              bheN,
  output logic              dtR,
  output logic [DATA_W-1:0] rdData
);
  localparam int UW = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] rAddr;
  logic [DATA_W-1:0] rWdata;
  logic [1:0]        rSeg;
  logic              rWrite, rMem, rHigh;

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      rAddr  <= '0;
      rWdata <= '0;
      rSeg   <= '0;
      rWrite <= 1'b0;
      rMem   <= 1'b1;
      rHigh  <= 1'b0;
      rdData <= '0;
    end else begin
      if (ctl.load) begin
        rAddr  <= reqAddr;
        rWdata <= reqWdata;
        rSeg   <= reqSeg;
        rWrite <= reqWrite;
        rMem   <= reqMem;
        rHigh  <= reqHigh;
      end
      if (ctl.capture) rdData <= adIn;
    end
  end

  assign isWrite  = rWrite;
  assign adOut    = ctl.addrPhase ? rAddr[DATA_W-1:0] : rWdata;
  assign adOe     = ctl.addrPhase || ctl.drvData;
  assign addrStat = ctl.addrPhase ? rAddr[ADDR_W-1:DATA_W]
                  : (ctl.statPhase ? UW'(rSeg) : '0);
  assign mIo      = rMem;
  assign bheN     = !rHigh;
  assign dtR      = rWrite;
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int RST_MIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqMem,
  input  logic [1:0]        reqSeg,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqHigh,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqTaken,
  output logic              reqDone,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  input  logic [DATA_W-1:0] adIn,
  output logic [ADDR_W-DATA_W-1:0] addrStat,
  output logic              ale,
  output logic              bheN,
  output logic              rdN,
  output logic              wrN,
  output logic              denN,
  output logic              dtR,
  output logic              mIo,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda,
  output logic              busOe
);
  dpCtl_t ctl;
  logic   isWrite;

  mbus_ctrl #(.RST_MIN(RST_MIN)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .ready(ready), .hold(hold),
    .isWrite(isWrite), .ctl(ctl), .ale(ale), .rdN(rdN), .wrN(wrN),
    .denN(denN), .hlda(hlda), .busOe(busOe), .reqTaken(reqTaken),
    .reqDone(reqDone)
  );

  mbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .ctl(ctl), .reqWrite(reqWrite), .reqMem(reqMem),
    .reqSeg(reqSeg), .reqAddr(reqAddr), .reqHigh(reqHigh),
    .reqWdata(reqWdata), .adIn(adIn), .isWrite(isWrite), .adOut(adOut),
    .adOe(adOe), .addrStat(addrStat), .mIo(mIo), .bheN(bheN), .dtR(dtR),
    .rdData(rdData)
  );
endmodule

// File: rtl/mbus_chk.sv
module mbus_chk #(
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ale,
  input logic          rdN,
  input logic          wrN,
  input logic          adOe,
  input logic          dtR,
  input logic          mIo,
  input logic          ready,
  input logic          hlda,
  input logic          busOe,
  input logic          reqDone,
  input logic [SW-1:0] addrStat
);
  assert_ale_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  assert_status_phase_R2: assert property (@(posedge clk) disable iff (rst)
    (!rdN || !wrN) |-> (addrStat[SW-1:2] == '0));

  assert_read_float_R3: assert property (@(posedge clk) disable iff (rst)
    !rdN |-> (!adOe && !dtR));

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN));

  assert_write_drive_R4: assert property (@(posedge clk) disable iff (rst)
    !wrN |-> (adOe && dtR));

  assert_wait_rd_R5: assert property (@(posedge clk) disable iff (rst)
    (!rdN && !ready) |=> !rdN);

  assert_wait_wr_R5: assert property (@(posedge clk) disable iff (rst)
    (!wrN && !ready) |=> !wrN);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    reqDone |=> !reqDone);

  assert_mio_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!rdN || !wrN) |-> $stable(mIo));

  assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!busOe && !adOe && !ale && rdN && wrN));
endmodule

bind mux_bus_seq mbus_chk #(.SW(ADDR_W - DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .rdN(rdN), .wrN(wrN), .adOe(adOe),
  .dtR(dtR), .mIo(mIo), .ready(ready), .hlda(hlda), .busOe(busOe),
  .reqDone(reqDone), .addrStat(addrStat)
);

// File: tb/tb_mux_bus_seq.sv
`timescale 1ns/1ps
module tb_mux_bus_seq;
  logic clk = 0, rst = 1;
  logic reqValid = 0, reqWrite = 0, reqMem = 1, reqHigh = 0;
  logic [1:0]  reqSeg = 0;
  logic [19:0] reqAddr = 0;
  logic [15:0] reqWdata = 0, adIn = 0;
  logic ready = 1, hold = 0;
  logic reqTaken, reqDone, adOe, ale, bheN, rdN, wrN, denN, dtR, mIo, hlda, busOe;
  logic [15:0] rdData, adOut;
  logic [3:0]  addrStat;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  mux_bus_seq dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMem(reqMem), .reqSeg(reqSeg), .reqAddr(reqAddr), .reqHigh(reqHigh),
    .reqWdata(reqWdata), .reqTaken(reqTaken), .reqDone(reqDone),
    .rdData(rdData), .adOut(adOut), .adOe(adOe), .adIn(adIn),
    .addrStat(addrStat), .ale(ale), .bheN(bheN), .rdN(rdN), .wrN(wrN),
    .denN(denN), .dtR(dtR), .mIo(mIo), .ready(ready), .hold(hold),
    .hlda(hlda), .busOe(busOe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nextCyc();
    @(negedge clk); #1;
  endtask

  // present a request, return in T1 (after the falling edge)
  task automatic startReq(input logic wr, input logic mem, input logic [1:0] seg,
                          input logic [19:0] addr, input logic hi, input logic [15:0] wd);
    @(negedge clk);
    reqWrite = wr; reqMem = mem; reqSeg = seg; reqAddr = addr;
    reqHigh = hi; reqWdata = wd; reqValid = 1;
    #1;
    for (int i = 0; i < 20 && !reqTaken; i++) nextCyc();
    @(negedge clk); reqValid = 0; #1;
  endtask

  task automatic finishCyc();
    for (int i = 0; i < 30 && !reqDone; i++) nextCyc();
    nextCyc();
  endtask

  task automatic testReset();
    check("R11 ale", ale, 0); check("R11 rdN", rdN, 1); check("R11 wrN", wrN, 1);
    check("R11 denN", denN, 1); check("R11 adOe", adOe, 0); check("R11 hlda", hlda, 0);
    check("R11 busOe", busOe, 1); check("R11 reqDone", reqDone, 0);
    check("R11 addrStat", addrStat, 0); check("R11 bheN", bheN, 1);
    check("R11 mIo", mIo, 1); check("R11 dtR", dtR, 0);
  endtask

  task automatic testRead();
    startReq(0, 1, 2'd2, 20'hA5C3E, 1, 16'h0);
    check("R1 ale", ale, 1); check("R1 adOe", adOe, 1); check("R1 adOut", adOut, 16'h5C3E);
    check("R1 upper", addrStat, 4'hA); check("R1 bheN", bheN, 0);
    check("R7 mIo mem", mIo, 1); check("R3 dtR", dtR, 0); check("R3 rdN T1", rdN, 1);
    nextCyc(); adIn = 16'h1234;
    check("R1 ale T2", ale, 0); check("R3 rdN T2", rdN, 0); check("R3 adOe T2", adOe, 0);
    check("R3 denN T2", denN, 0); check("R2 status", addrStat, 4'h2);
    nextCyc();
    check("R3 rdN T3", rdN, 0); check("R2 status T3", addrStat, 4'h2);
    nextCyc();
    check("R6 done", reqDone, 1); check("R6 rdData", rdData, 16'h1234);
    check("R3 rdN T4", rdN, 1); check("R3 denN T4", denN, 1); check("R7 mIo T4", mIo, 1);
    nextCyc();
    check("R2 idle status", addrStat, 0); check("R6 done idle", reqDone, 0);
  endtask

  task automatic testWriteWait();
    startReq(1, 0, 2'd1, 20'h300F0, 0, 16'hBEEF);
    ready = 0;
    check("R1 adOut wr", adOut, 16'h00F0); check("R1 upper wr", addrStat, 4'h3);
    check("R1 bheN low-only", bheN, 1); check("R7 mIo io", mIo, 0); check("R4 dtR", dtR, 1);
    nextCyc();
    check("R4 wrN T2", wrN, 0); check("R4 adOe T2", adOe, 1);
    check("R4 data T2", adOut, 16'hBEEF); check("R4 denN T2", denN, 0);
    nextCyc();
    check("R4 wrN T3", wrN, 0);
    nextCyc();
    check("R5 wrN Tw1", wrN, 0); check("R5 no done Tw1", reqDone, 0);
    check("R5 data Tw1", adOut, 16'hBEEF); check("R7 mIo Tw", mIo, 0);
    nextCyc();
    check("R5 wrN Tw2", wrN, 0); check("R5 no done Tw2", reqDone, 0);
    ready = 1;
    nextCyc();
    check("R5 done", reqDone, 1); check("R4 wrN T4", wrN, 1); check("R4 adOe T4", adOe, 1);
    check("R4 data T4", adOut, 16'hBEEF); check("R4 denN T4", denN, 0);
    nextCyc();
    check("R4 adOe idle", adOe, 0);
  endtask

  task automatic testReadWait();
    startReq(0, 1, 2'd3, 20'h0BEEE, 0, 16'h0);
    ready = 0;
    nextCyc(); adIn = 16'h1111;
    nextCyc(); adIn = 16'h2222;
    nextCyc(); adIn = 16'h3333;
    check("R5 rdN Tw1", rdN, 0); check("R5 denN Tw1", denN, 0);
    nextCyc(); adIn = 16'h4444; ready = 1;
    check("R5 rdN Tw2", rdN, 0);
    nextCyc();
    check("R6 done wait", reqDone, 1); check("R6 last sample", rdData, 16'h4444);
    nextCyc();
  endtask

  task automatic testBackToBack();
    startReq(0, 1, 2'd0, 20'h11111, 0, 16'h0);
    nextCyc(); nextCyc();
    reqAddr = 20'h2ABCD; reqWrite = 1; reqWdata = 16'h5555; reqValid = 1; #1;
    check("R8 not taken T3", reqTaken, 0);
    nextCyc();
    check("R8 taken T4", reqTaken, 1); check("R8 done T4", reqDone, 1);
    @(negedge clk); reqValid = 0; #1;
    check("R8 ale b2b", ale, 1); check("R8 addr b2b", adOut, 16'hABCD);
    finishCyc();
  endtask

  task automatic testHoldIdle();
    @(negedge clk);
    hold = 1; reqWrite = 0; reqMem = 1; reqAddr = 20'h0_0042; reqValid = 1; #1;
    check("R9 hold blocks take", reqTaken, 0);
    nextCyc();
    check("R9 hlda", hlda, 1); check("R9 busOe", busOe, 0);
    check("R9 adOe", adOe, 0); check("R9 ale", ale, 0);
    nextCyc();
    check("R9 hlda held", hlda, 1); check("R9 no take in hold", reqTaken, 0);
    hold = 0;
    nextCyc();
    check("R9 release hlda", hlda, 0); check("R9 release busOe", busOe, 1);
    check("R9 take after", reqTaken, 1);
    @(negedge clk); reqValid = 0; #1;
    check("R9 pending starts", ale, 1);
    finishCyc();
  endtask

  task automatic testHoldMid();
    startReq(0, 1, 2'd0, 20'h01000, 0, 16'h0);
    hold = 1;
    nextCyc();
    check("R10 hlda T2", hlda, 0); check("R10 busOe T2", busOe, 1);
    nextCyc();
    check("R10 hlda T3", hlda, 0);
    nextCyc();
    check("R10 T4 done", reqDone, 1); check("R10 hlda T4", hlda, 0);
    nextCyc();
    check("R10 hlda after T4", hlda, 1); check("R10 busOe after", busOe, 0);
    hold = 0;
    nextCyc();
    check("R10 release", hlda, 0);
  endtask

  task automatic testResetAbort();
    startReq(1, 1, 2'd0, 20'h07777, 1, 16'hCAFE);
    nextCyc();
    rst = 1; reqWrite = 0; reqAddr = 20'h12345; reqValid = 1; #1;
    check("R11 abort wrN", wrN, 1); check("R11 abort denN", denN, 1);
    check("R11 abort adOe", adOe, 0); check("R11 abort take", reqTaken, 0);
    @(negedge clk); rst = 0; #1;
    check("R12 stretch 1", reqTaken, 0); check("R12 ale 1", ale, 0);
    nextCyc(); check("R12 stretch 2", reqTaken, 0);
    nextCyc(); check("R12 stretch 3", reqTaken, 0);
    nextCyc(); check("R12 released", reqTaken, 1);
    @(negedge clk); reqValid = 0; #1;
    check("R12 start", ale, 1); check("R12 addr", adOut, 16'h2345);
    finishCyc();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  initial begin
    #200000;
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    #1; testReset();
    rst = 0;
    nextCyc(); testReset();
    testRead();
    testWriteWait();
    testReadWait();
    testBackToBack();
    testHoldIdle();
    testHoldMid();
    testResetAbort();
    summary();
    $finish;
  end
endmodule